// File: doc/BRIEF.md
# Audio Clock Synchronization Monitor

This block runs on the system master clock and watches two incoming audio clocks: the word clock, which marks one frame per sample, and the bit clock. Both are brought into the master-clock domain through multi-flop synchronizers. For each frame, the block counts the master-clock cycles and the bit-clock rising edges. It then judges the frame against two separate rules. The frame length must stay within a fixed tolerance of a reference length that the block learns. The bit-clock count must equal a configured value.

After reset, the block is unlocked and mutes the audio datapath. The first complete frame it sees becomes the reference length. Two consecutive frames that then meet both rules bring the block into lock and release the mute. While locked, any of the following drops lock at once:

- a frame that is too short;
- a frame that grows too long, caught as soon as it passes the tolerance, even if the word clock has stopped;
- more than four consecutive frames with the wrong bit-clock count.

A drop emits a single-cycle initialize pulse and restores the forced-zero mute. The mute holds until the full resync sequence completes again.

Top module: `audio_clk_sync_mon`

## Requirements
- R1: While reset is asserted, and directly after it, mute_o is 1 and locked_o and init_o are 0.
- R2: The first complete frame after reset or after a loss of lock sets the reference length. Lock is declared at the end of the second consecutive valid frame after that frame. A valid frame has a length within the tolerance and a bit-clock rising-edge count equal to bits_per_frame_i (unsigned binary).
- R3: While locked, a frame whose master-clock length lies within 5 cycles of the reference, either way, keeps lock. For a 64-cycle reference, lengths 59 to 69 are accepted.
- R4: While locked, a frame shorter than the reference minus 5 drops lock at its end. A frame that runs past the reference plus 5 drops lock as soon as it passes that limit, without waiting for the next word-clock edge.
- R5: While locked, up to 4 consecutive frames with a wrong bit-clock count keep lock. The fifth consecutive wrong frame drops lock. A frame with the correct count clears the run.
- R6: Each loss of lock produces exactly one init_o pulse, one master-clock cycle wide, in the cycle in which locked_o falls. No further pulses follow while the block stays unlocked.
- R7: mute_o is 1 whenever locked_o is 0, and it stays 1 until lock is regained through the R2 sequence.
- R8: While unlocked, a valid-length check failure against the current reference replaces the reference with the length of the failing frame and restarts the count of valid frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | System master clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wclk_i | input | 1 | Word clock; its rising edge starts a frame |
| bclk_i | input | 1 | Bit clock; rising edges are counted per frame |
| bits_per_frame_i | input | BCNT_W (8) | Expected bit-clock rising edges per frame |
| mute_o | output | 1 | Forces the audio output to zero while high |
| locked_o | output | 1 | Clocks are in a valid, stable relationship |
| init_o | output | 1 | One-cycle pulse that reinitializes the datapath on loss of lock |

## Verification
A wrong reference or a bad-frame counter that is off by one shows at the ports as a locked_o edge one frame early or one frame late. The bench therefore samples lock, mute and the number of init pulses at the end of every frame. A stall detector that fails shows up as locked_o staying high through a word-clock gap that is longer than the tolerance. A missed or doubled init pulse shows up as a wrong pulse total or a pulse two cycles wide, visible in the cycle of the drop.

// File: rtl/asm_pkg.sv
package asm_pkg;
   typedef enum logic {
      ST_HUNT = 1'b0,
      ST_LOCK = 1'b1
   } lock_st_e;
endpackage

// File: rtl/asm_edge_sync.sv
module asm_edge_sync #(
   parameter int STAGES    = 2,
   parameter bit EDGE_RISE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic edge_o
);
   logic [STAGES-1:0] sh_q;
   logic              prev_q;
   logic              lvl;

   if (STAGES < 2) begin : g_bad_stages
      $error("asm_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], d};
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign lvl = sh_q[STAGES-1];

   if (EDGE_RISE) begin : g_rise
      assign edge_o = lvl & ~prev_q;
   end else begin : g_fall
      assign edge_o = ~lvl & prev_q;
   end
endmodule

// File: rtl/asm_frame_meter.sv
module asm_frame_meter #(
   parameter int CNT_W  = 12,
   parameter int BCNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_edge,
   input  logic              bck_rise,
   output logic              frame_done,
   output logic [CNT_W-1:0]  run_len,
   output logic [BCNT_W-1:0] bck_total
);
   localparam logic [CNT_W-1:0]  CMAX = {CNT_W{1'b1}};
   localparam logic [BCNT_W-1:0] BMAX = {BCNT_W{1'b1}};

   logic [CNT_W-1:0]  cnt_q;
   logic [BCNT_W-1:0] bcnt_q;
   logic              primed_q;

   // length of the current frame if it ended in this cycle (saturating)
   assign run_len    = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
   assign bck_total  = (bck_rise && bcnt_q != BMAX) ? bcnt_q + 1'b1 : bcnt_q;
   assign frame_done = frame_edge & primed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         bcnt_q   <= '0;
         primed_q <= 1'b0;
      end else if (frame_edge) begin
         cnt_q    <= '0;
         bcnt_q   <= '0;
         primed_q <= 1'b1;
      end else begin
         cnt_q    <= run_len;
         bcnt_q   <= bck_total;
      end
   end

   // R4: a stalled word clock leaves the length pinned at its maximum, never wrapping
   a_r4_len_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CMAX && !frame_edge) |=> (cnt_q == CMAX));
endmodule

// File: rtl/asm_lock_fsm.sv
module asm_lock_fsm
   import asm_pkg::*;
#(
   parameter int CNT_W         = 12,
   parameter int BCNT_W        = 8,
   parameter int MCLK_TOL      = 5,
   parameter int BCK_BAD_LIMIT = 4,
   parameter int RESYNC_FRAMES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_done,
   input  logic [CNT_W-1:0]  run_len,
   input  logic [BCNT_W-1:0] bck_total,
   input  logic [BCNT_W-1:0] exp_bck,
   output logic              mute,
   output logic              locked,
   output logic              init_pulse
);
   localparam int GOOD_W = $clog2(RESYNC_FRAMES + 1);
   localparam int BAD_W  = $clog2(BCK_BAD_LIMIT + 1);
   localparam logic [CNT_W:0]    TOL_W     = (CNT_W+1)'(MCLK_TOL);
   localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(RESYNC_FRAMES - 1);
   localparam logic [BAD_W-1:0]  BAD_LAST  = BAD_W'(BCK_BAD_LIMIT);

   lock_st_e          st_q;
   logic [CNT_W-1:0]  ref_q;
   logic              ref_v_q;
   logic [GOOD_W-1:0] good_q;
   logic [BAD_W-1:0]  bad_q;
   logic              mute_q, locked_q, init_q;

   logic [CNT_W:0] hi_lim;
   logic           too_long, too_short, len_ok, bck_ok, loss;

   assign hi_lim    = {1'b0, ref_q} + TOL_W;
   assign too_long  = {1'b0, run_len} > hi_lim;
   assign too_short = ({1'b0, run_len} + TOL_W) < {1'b0, ref_q};
   assign len_ok    = !too_long && !too_short;
   assign bck_ok    = (bck_total == exp_bck);

   // loss rules while locked: overrun any cycle, underrun or bit-clock run at a frame end
   assign loss = (st_q == ST_LOCK) &&
                 (too_long ||
                  (frame_done && too_short) ||
                  (frame_done && !bck_ok && bad_q == BAD_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_HUNT;
         ref_q    <= '0;
         ref_v_q  <= 1'b0;
         good_q   <= '0;
         bad_q    <= '0;
         mute_q   <= 1'b1;
         locked_q <= 1'b0;
         init_q   <= 1'b0;
      end else begin
         init_q <= 1'b0;
         unique case (st_q)
            ST_HUNT: begin
               if (frame_done) begin
                  if (!ref_v_q || !len_ok) begin
                     ref_q   <= run_len;
                     ref_v_q <= 1'b1;
                     good_q  <= '0;
                  end else if (!bck_ok) begin
                     good_q <= '0;
                  end else if (good_q == GOOD_LAST) begin
                     st_q     <= ST_LOCK;
                     good_q   <= '0;
                     bad_q    <= '0;
                     mute_q   <= 1'b0;
                     locked_q <= 1'b1;
                  end else begin
                     good_q <= good_q + 1'b1;
                  end
               end
            end
            ST_LOCK: begin
               if (loss) begin
                  st_q     <= ST_HUNT;
                  ref_v_q  <= 1'b0;
                  good_q   <= '0;
                  bad_q    <= '0;
                  mute_q   <= 1'b1;
                  locked_q <= 1'b0;
                  init_q   <= 1'b1;
               end else if (frame_done) begin
                  bad_q <= bck_ok ? '0 : bad_q + 1'b1;
               end
            end
            default: st_q <= ST_HUNT;
         endcase
      end
   end

   assign mute       = mute_q;
   assign locked     = locked_q;
   assign init_pulse = init_q;

   // R6: the init pulse is one cycle wide
   a_r6_init_single: assert property (@(posedge clk) disable iff (!rst_n)
      init_q |=> !init_q);
   // R6: every drop of lock comes with the init pulse
   a_r6_init_at_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_q) |-> init_q);
   // R7: mute and lock are always complementary
   a_r7_mute_vs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      mute_q != locked_q);
   // R2: lock is only gained at a frame boundary
   a_r2_lock_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> $past(frame_done));
   // R5: bad bit-clock frame run never exceeds its limit
   a_r5_bad_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      bad_q <= BAD_LAST);
   // R3: reference is frozen while lock persists
   a_r3_ref_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && $past(locked_q)) |-> $stable(ref_q));
endmodule

// File: rtl/audio_clk_sync_mon.sv
module audio_clk_sync_mon #(
   parameter int CNT_W         = 12,
   parameter int BCNT_W        = 8,
   parameter int SYNC_STAGES   = 2,
   parameter bit FRAME_ON_RISE = 1'b1,
   parameter int MCLK_TOL      = 5,
   parameter int BCK_BAD_LIMIT = 4,
   parameter int RESYNC_FRAMES = 2
) (
   input  logic              mclk_i,
   input  logic              rst_ni,
   input  logic              wclk_i,
   input  logic              bclk_i,
   input  logic [BCNT_W-1:0] bits_per_frame_i,
   output logic              mute_o,
   output logic              locked_o,
   output logic              init_o
);
   if (CNT_W < 4) begin : g_bad_cnt
      $error("audio_clk_sync_mon: CNT_W too small");
   end
   if (BCNT_W < 2) begin : g_bad_bcnt
      $error("audio_clk_sync_mon: BCNT_W too small");
   end
   if (MCLK_TOL < 0 || MCLK_TOL >= (1 << (CNT_W - 1))) begin : g_bad_tol
      $error("audio_clk_sync_mon: MCLK_TOL out of range");
   end
   if (BCK_BAD_LIMIT < 1 || RESYNC_FRAMES < 1) begin : g_bad_limits
      $error("audio_clk_sync_mon: frame limits must be positive");
   end

   logic              frame_edge, bck_rise, frame_done;
   logic [CNT_W-1:0]  run_len;
   logic [BCNT_W-1:0] bck_total;

   asm_edge_sync #(.STAGES(SYNC_STAGES), .EDGE_RISE(FRAME_ON_RISE)) u_wsync (
      .clk(mclk_i), .rst_n(rst_ni), .d(wclk_i), .edge_o(frame_edge));

   asm_edge_sync #(.STAGES(SYNC_STAGES), .EDGE_RISE(1'b1)) u_bsync (
      .clk(mclk_i), .rst_n(rst_ni), .d(bclk_i), .edge_o(bck_rise));

   asm_frame_meter #(.CNT_W(CNT_W), .BCNT_W(BCNT_W)) u_meter (
      .clk(mclk_i), .rst_n(rst_ni), .frame_edge(frame_edge), .bck_rise(bck_rise),
      .frame_done(frame_done), .run_len(run_len), .bck_total(bck_total));

   asm_lock_fsm #(
      .CNT_W(CNT_W), .BCNT_W(BCNT_W), .MCLK_TOL(MCLK_TOL),
      .BCK_BAD_LIMIT(BCK_BAD_LIMIT), .RESYNC_FRAMES(RESYNC_FRAMES)
   ) u_fsm (
      .clk(mclk_i), .rst_n(rst_ni), .frame_done(frame_done), .run_len(run_len),
      .bck_total(bck_total), .exp_bck(bits_per_frame_i),
      .mute(mute_o), .locked(locked_o), .init_pulse(init_o));
endmodule

// File: tb/tb_audio_clk_sync_mon.sv
module tb_audio_clk_sync_mon;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ws = 1'b0;
   logic       bck = 1'b0;
   logic [7:0] bpf = 8'd16;
   logic       mute, locked, init;

   int n_chk = 0, n_err = 0;
   int n_init = 0, width_bad = 0;
   logic init_prev = 1'b0;
   bit done = 1'b0;

   audio_clk_sync_mon dut (
      .mclk_i(clk), .rst_ni(rst_n), .wclk_i(ws), .bclk_i(bck),
      .bits_per_frame_i(bpf), .mute_o(mute), .locked_o(locked), .init_o(init));

   always #5 clk = ~clk;

   // count init pulses and catch any pulse wider than one cycle
   always @(negedge clk) begin
      if (init) n_init++;
      if (init && init_prev) width_bad++;
      init_prev = init;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one frame: word clock high for first half, b bit-clock rises at odd cycles
   task automatic frame(input int len, input int b);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         ws  = (i < len / 2);
         bck = (i < 2 * b) && (i % 2 == 1);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ws  = 1'b0;
         bck = 1'b0;
      end
   endtask

   localparam int ROWS = 31;
   localparam int LEN_T[ROWS] = '{64,64,64,64,67,59,64,64,64,64,64,64,64,64,64,64,
                                  64,64,64,64,64,58,64,64,64,64,200,64,64,64,64};
   localparam int BCK_T[ROWS] = '{16,16,16,16,16,16,16,15,15,15,15,16,15,15,15,15,
                                  15,16,16,16,16,16,16,16,16,16,16,16,16,16,16};
   localparam int LCK_T[ROWS] = '{0,0,0,1,1,1,1,1,1,1,1,1,1,1,1,1,
                                  1,0,0,0,1,1,0,0,0,1,0,0,0,0,1};
   localparam int INI_T[ROWS] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,
                                  0,1,1,1,1,1,2,2,2,2,3,3,3,3,3};

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
         end
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      chk("R1 mute in reset", mute, 1);
      chk("R1 locked in reset", locked, 0);
      chk("R1 init in reset", init, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 mute after reset", mute, 1);

      // R2 lock sequence, R3 tolerance, R5 bit-clock run, R4 short/long frames, R7 mute
      for (int r = 0; r < ROWS; r++) begin
         frame(LEN_T[r], BCK_T[r]);
         chk($sformatf("R2/R3/R4/R5 locked row %0d", r), locked, LCK_T[r]);
         chk($sformatf("R7 mute row %0d", r), mute, 1 - LCK_T[r]);
         chk($sformatf("R6 init count row %0d", r), n_init, INI_T[r]);
      end

      // R1: reset while locked
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 mute on mid-run reset", mute, 1);
      chk("R1 locked on mid-run reset", locked, 0);
      rst_n = 1'b1;
      idle(2);
      base = n_init;
      for (int k = 0; k < 4; k++) frame(64, 16);
      chk("R2 relock after reset", locked, 1);

      // R4: word clock stops; overrun detected without an edge
      idle(120);
      chk("R4 stall drops lock", locked, 0);
      chk("R6 one pulse on stall", n_init - base, 1);
      idle(300);
      chk("R6 no extra pulses while unlocked", n_init - base, 1);
      chk("R7 mute held while unlocked", mute, 1);

      // R8: stall frame becomes reference, then replaced by the 64-cycle length
      frame(64, 16);
      frame(64, 16);
      frame(64, 16);
      chk("R8 reference retaken, not yet locked", locked, 0);
      frame(64, 16);
      chk("R8 lock after retaken reference", locked, 1);
      chk("R7 mute released on lock", mute, 0);
      chk("R6 init pulse width", width_bad, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule